// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block holds the digital control for an 8-bit port whose pins behave as the classic microcontroller quasi-bidirectional kind. Each bit has a software output latch. For every pin the block drives three pad control enables: a strong sink, a brief strong source, and a weak source. An external pad model turns these enables into the pin level. A pin whose latch holds 1 sits on the weak source only. It therefore also serves as an input, because any outside driver can pull it low.

The drive for each bit is sequenced from an effective value. That value is the latch bit, or a peripheral value when the bit is handed to an alternate function such as an address line, a chip select or a serial line. When the effective value drops to 0, the sink turns on and stays on. When it rises from 0 to 1, the strong source fires for a fixed, parameterised number of cycles. After that, only the weak source remains. Software updates the latch through a byte strobe with a per-bit mask. Software reads back either the pin levels or the latch, through a registered read path.

Top module: `qport_ctrl`

## Requirements
- R1: After synchronous reset, every latch bit reads 1, `wpu_en` is all ones, and `pd_en` and `spu_en` are all zeros.
- R2: A write (`wr_en`=1 at a clock edge) sets latch bit i to `wr_data[i]` only where `wr_mask[i]`=1. Other bits keep their value.
- R3: Once a bit's effective value is 0, its `pd_en` bit is 1. It stays 1 until a 1 reaches that bit or reset occurs. A latch write shows on the enables at the second edge after the strobe is sampled.
- R4: A 0-to-1 change of a bit's effective value raises its `spu_en` for exactly PULSE_CYCLES consecutive cycles. After that, `wpu_en` is 1 for that bit.
- R5: Writing 1 to a bit whose effective value is already 1 starts no `spu_en` pulse.
- R6: A 0 reaching a bit during its pulse drops `spu_en` and raises `pd_en` at the same edge.
- R7: In every cycle, each bit has exactly one of `pd_en`, `spu_en` and `wpu_en` set.
- R8: When `alt_sel[i]`=1, `alt_val[i]` is the effective value and drives the same sequencing. An `alt_val` change shows on the enables one edge after it is sampled.
- R9: While `alt_sel[i]`=1, latch writes to bit i are stored and readable, but they do not change the enables. When `alt_sel[i]` returns to 0, the stored value takes over.
- R10: `rd_data` is registered. One edge after sampling, it shows `pin_in` when `rd_sel`=0 and the latch when `rd_sel`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | 8 | Latch write data |
| wr_mask | input | 8 | Per-bit write enable mask |
| alt_sel | input | 8 | Per-bit alternate function select |
| alt_val | input | 8 | Peripheral output values |
| pin_in | input | 8 | Sensed pin levels from the pad |
| rd_sel | input | 1 | Read source: 0 pins, 1 latch |
| rd_data | output | 8 | Registered read data |
| pd_en | output | 8 | Strong sink enables |
| spu_en | output | 8 | Momentary strong source enables |
| wpu_en | output | 8 | Weak source enables |

## Verification
The embedded assertions check the following on every cycle: each bit has exactly one drive enable, a low effective value is followed by the sink, and a rising effective value is followed by the strong source. They also check that no pulse runs longer than its length, that a steady high value never re-arms the pulse, and that masked-off latch bits never change. The bench scenarios are what show the rest. These are the exact pulse length and the cancel of a pulse by a 0, the alternate-function handover in both directions, latch contents stored while not driven, and which source the registered read path selects.

// File: rtl/qport_pkg.sv
package qport_pkg;
  // One-hot drive state: each bit is one pad enable.
  typedef enum logic [2:0] {
    DRV_WEAK  = 3'b001,
    DRV_BOOST = 3'b010,
    DRV_SINK  = 3'b100
  } drive_e;
endpackage

// File: rtl/qport_latch.sv
module qport_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] wr_mask,
  output logic [WIDTH-1:0] latch_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
    end else if (wr_en) begin
      latch_q <= (latch_q & ~wr_mask) | (wr_data & wr_mask);
    end
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R2: bits outside the mask never move
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && wr_en) |=> (((latch_q ^ $past(latch_q)) & ~$past(wr_mask)) == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && !wr_en) |=> $stable(latch_q));
endmodule

// File: rtl/qport_bit_seq.sv
module qport_bit_seq
  import qport_pkg::*;
#(
  parameter int PULSE_CYCLES = 2,
  parameter int CNT_W        = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic eff,
  output logic pd,
  output logic spu,
  output logic wpu
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES - 1);

  drive_e           st;
  logic             prev;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= DRV_WEAK;
      prev <= 1'b1;
      cnt  <= '0;
    end else begin
      prev <= eff;
      if (!eff) begin
        st  <= DRV_SINK;
        cnt <= '0;
      end else if (!prev) begin
        st  <= DRV_BOOST;
        cnt <= LOAD;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        st <= DRV_WEAK;
      end
    end
  end

  assign pd  = st[2];
  assign spu = st[1];
  assign wpu = st[0];

  // Checker state
  logic armed;
  int   run_len;
  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      run_len <= 0;
    end else begin
      armed   <= 1'b1;
      run_len <= spu ? run_len + 1 : 0;
    end
  end

  assert_one_drive_R7: assert property (@(posedge clk) disable iff (rst)
    $countones({pd, spu, wpu}) == 1);

  assert_sink_follows_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && !eff) |=> (pd && !spu));

  assert_boost_start_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(eff)) |=> spu);

  assert_boost_len_R4: assert property (@(posedge clk) disable iff (rst)
    run_len <= PULSE_CYCLES);

  assert_no_rearm_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && eff && $stable(eff) && !spu) |=> !spu);
endmodule

// File: rtl/qport_readback.sv
module qport_readback #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_sel,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel ? latch_q : pin_in;
  end
endmodule

// File: rtl/qport_ctrl.sv
module qport_ctrl #(
  parameter int WIDTH        = 8,
  parameter int PULSE_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] wr_mask,
  input  logic [WIDTH-1:0] alt_sel,
  input  logic [WIDTH-1:0] alt_val,
  input  logic [WIDTH-1:0] pin_in,
  input  logic             rd_sel,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] pd_en,
  output logic [WIDTH-1:0] spu_en,
  output logic [WIDTH-1:0] wpu_en
);
  localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;

  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] eff;

  qport_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_data(wr_data), .wr_mask(wr_mask), .latch_q(latch_q)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign eff[i] = alt_sel[i] ? alt_val[i] : latch_q[i];

    qport_bit_seq #(.PULSE_CYCLES(PULSE_CYCLES), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst(rst), .eff(eff[i]),
      .pd(pd_en[i]), .spu(spu_en[i]), .wpu(wpu_en[i])
    );
  end

  qport_readback #(.WIDTH(WIDTH)) u_rd (
    .clk(clk), .rst(rst), .rd_sel(rd_sel),
    .pin_in(pin_in), .latch_q(latch_q), .rd_data(rd_data)
  );

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R9: a latch write to bits fully owned by a steady peripheral leaves sink enables alone
  assert_alt_isolated_R9: assert property (@(posedge clk) disable iff (rst)
    (armed && wr_en && ((wr_mask & ~alt_sel) == '0) && $stable(alt_sel) && $stable(alt_val))
      |=> ((pd_en & alt_sel) == ($past(pd_en) & alt_sel)));
endmodule

// File: tb/qport_ctrl_bench.sv
module qport_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int PULSE = 4;

  logic       clk = 0;
  logic       rst = 1;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0, wr_mask = 0, alt_sel = 0, alt_val = 0, pin_in = 0;
  logic       rd_sel = 1;
  logic [7:0] rd_data, pd_en, spu_en, wpu_en;

  always #(CLK_P/2) clk = ~clk;

  qport_ctrl #(.WIDTH(8), .PULSE_CYCLES(PULSE)) u_qport_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
    .alt_sel(alt_sel), .alt_val(alt_val), .pin_in(pin_in), .rd_sel(rd_sel),
    .rd_data(rd_data), .pd_en(pd_en), .spu_en(spu_en), .wpu_en(wpu_en)
  );

  // kinds: 0 pd, 1 spu, 2 wpu, 3 rd, 4 enable overlap/gap vector
  typedef struct {
    string      req;
    int         kind;
    logic [7:0] mask;
    logic [7:0] exp;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  task automatic expect_v(input string r, input int k, input logic [7:0] m, input logic [7:0] e);
    item_t it;
    it.req = r; it.kind = k; it.mask = m; it.exp = e;
    q.push_back(it);
  endtask

  task automatic flush();
    -> chk_ev;
    #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d, input logic [7:0] m);
    wr_data = d; wr_mask = m; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  // Monitor: pops expected items and compares with outputs
  initial begin
    item_t      it;
    logic [7:0] act;
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        it = q.pop_front();
        case (it.kind)
          0: act = pd_en;
          1: act = spu_en;
          2: act = wpu_en;
          3: act = rd_data;
          default: act = (pd_en & spu_en) | (pd_en & wpu_en) | (spu_en & wpu_en)
                         | ~(pd_en | spu_en | wpu_en);
        endcase
        n_chk++;
        if ((act & it.mask) !== (it.exp & it.mask)) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%b expected=%b mask=%b",
                   it.req, it.kind, act, it.exp, it.mask);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 0;
    step(1);
    // R1 reset state
    expect_v("R1", 2, 8'hFF, 8'hFF);
    expect_v("R1", 0, 8'hFF, 8'h00);
    expect_v("R1", 1, 8'hFF, 8'h00);
    expect_v("R1", 3, 8'hFF, 8'hFF);
    expect_v("R7", 4, 8'hFF, 8'h00);
    flush();

    // R2/R3 masked clear of low nibble
    wr(8'h00, 8'h0F);
    step(1);
    expect_v("R3", 0, 8'hFF, 8'h0F);
    expect_v("R3", 2, 8'hFF, 8'hF0);
    expect_v("R2", 3, 8'hFF, 8'hF0);
    flush();
    step(3);
    expect_v("R3", 0, 8'hFF, 8'h0F);
    flush();

    // R4 0->1 on bits 1:0, pulse of PULSE cycles
    wr(8'hFF, 8'h03);
    step(1);
    expect_v("R4", 1, 8'hFF, 8'h03);
    expect_v("R4", 0, 8'hFF, 8'h0C);
    expect_v("R7", 4, 8'hFF, 8'h00);
    flush();
    for (int k = 1; k < PULSE; k++) begin
      step(1);
      expect_v("R4", 1, 8'h03, 8'h03);
      flush();
    end
    step(1);
    expect_v("R4", 1, 8'hFF, 8'h00);
    expect_v("R4", 2, 8'hFF, 8'hF3);
    flush();

    // R5 writing 1 over 1 gives no pulse
    wr(8'hFF, 8'hF0);
    step(1);
    expect_v("R5", 1, 8'hFF, 8'h00);
    flush();
    step(1);
    expect_v("R5", 1, 8'hFF, 8'h00);
    expect_v("R5", 2, 8'hF0, 8'hF0);
    flush();

    // R6 cancel an active pulse on bit 2
    wr(8'hFF, 8'h04);
    step(1);
    expect_v("R6", 1, 8'h04, 8'h04);
    flush();
    wr(8'h00, 8'h04);
    step(1);
    expect_v("R6", 1, 8'h04, 8'h00);
    expect_v("R6", 0, 8'h04, 8'h04);
    expect_v("R7", 4, 8'hFF, 8'h00);
    flush();

    // R10 read path
    rd_sel = 0; pin_in = 8'hA5;
    step(1);
    expect_v("R10", 3, 8'hFF, 8'hA5);
    flush();
    pin_in = 8'h3C;
    step(1);
    expect_v("R10", 3, 8'hFF, 8'h3C);
    flush();
    rd_sel = 1;
    step(1);
    expect_v("R10", 3, 8'hFF, 8'hF3);
    flush();

    // R8 alternate function drives bit 7
    alt_sel = 8'h80; alt_val = 8'h00;
    step(1);
    expect_v("R8", 0, 8'h80, 8'h80);
    flush();
    alt_val = 8'h80;
    step(1);
    expect_v("R8", 1, 8'h80, 8'h80);
    flush();
    step(PULSE);
    expect_v("R8", 1, 8'h80, 8'h00);
    expect_v("R8", 2, 8'h80, 8'h80);
    flush();

    // R9 latch write while in alternate mode: stored, not driven
    wr(8'h00, 8'h80);
    step(2);
    expect_v("R9", 0, 8'h80, 8'h00);
    expect_v("R9", 2, 8'h80, 8'h80);
    expect_v("R9", 3, 8'h80, 8'h00);
    flush();
    alt_sel = 8'h00;
    step(1);
    expect_v("R9", 0, 8'h80, 8'h80);
    expect_v("R7", 4, 8'hFF, 8'h00);
    flush();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule